// File: doc/BRIEF.md
# Eight-Digit Display Write Controller

This block sits between a processor bus and an eight-digit seven-segment scanner. It holds the display control state and the per-digit display memory. Every bus write carries an 8-bit byte and a select line. With the select high the byte is a control word. With the select low the byte is display data. The write strobe is asynchronous to the block clock. It is brought in through a synchronizer, and a write commits when a rising strobe edge is detected.

A control word either starts an automatic fill or arms one addressed digit. In an automatic fill, the next eight data writes land in digits 0 to 7 in order, and the display stays blanked until the fill ends. An armed digit takes exactly the next data write. A control word with no following data write changes only the global settings. Each digit keeps two 4-bit character slots, one per bank, plus a shared decimal-point bit and its own raw/decoded flag. The scanner picks a digit through a read index and receives the byte to show, that digit's decode flag, the blank and shutdown levels and the character-set select.

Top module: `disp_wr_ctrl`

## Requirements
- R1: After reset, shutdown is 1, blank is 0, hex_sel is 0, and every digit reads back as decoded (rd_decoded=1) with rd_byte=0x00. No fill and no armed digit are pending, so a data write before any control word changes nothing.
- R2: A control write (mode_in=1) latches these fields. Bit 6 high selects hexadecimal (hex_sel=1). Bit 5 high selects raw/no-decode for later data writes. Bit 4 low selects shutdown (shutdown=1). Bit 3 high selects bank A and low selects bank B.
- R3: A control word with bit 7 high raises blank. The next eight data writes fill digits 0,1,...,7 in that order. blank stays high through the seventh of these writes and falls with the eighth.
- R4: Once a fill has completed, further data writes leave every digit unchanged until the next control word.
- R5: A control word with bit 7 low arms the digit whose index is in bits 2..0, where 000 is digit 0. The next data write updates only that digit. Later data writes are ignored until the next control word.
- R6: A control word alone never alters stored digit contents. Only the displayed bank and the global settings change.
- R7: A decoded data write stores bits 3..0 in the slot of the bank chosen by the latest control word and stores bit 7 as the digit's decimal point. A decoded digit reads as {dp, 000, nibble of the currently selected bank}. The dp bit is shared by both banks.
- R8: A data write made while no-decode is selected stores the full byte and marks the digit raw (rd_decoded=0). A raw digit reads back that full byte whatever the selected bank.
- R9: The raw/decoded flag belongs to each digit and persists across later control words. hex_sel always follows the latest control word for all decoded digits.
- R10: Control and data writes are accepted and stored while shutdown is 1.
- R11: A write commits within four clock cycles after wr_in rises, provided mode_in and bus_in are held stable during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_in | input | 1 | Asynchronous write strobe; commits on its rising edge |
| mode_in | input | 1 | 1 = control word, 0 = display data |
| bus_in | input | 8 | Write data byte |
| rd_sel | input | AW (3) | Digit index requested by the scanner |
| rd_byte | output | 8 | Display byte of the selected digit |
| rd_decoded | output | 1 | 1 when the selected digit is shown through the character decoder |
| blank | output | 1 | High while an automatic fill is in progress |
| shutdown | output | 1 | High when the display is powered down |
| hex_sel | output | 1 | 1 = hexadecimal set, 0 = alternate set |

## Verification
The bench builds the block with its default eight digits and two synchronizer stages. With that setup every digit index can be swept. The test runs two complete automatic fills, one into each bank, and an armed write at every one of the eight addresses. With only eight digits, all digits are compared against a bench-side model after each step. This catches a write that lands in the wrong digit, in the wrong bank, or one that should have been dropped. It also shows how raw and decoded digits coexist across bank and character-set changes.

// File: rtl/dw_pkg.sv
package dw_pkg;
   typedef struct packed {
      logic hex;
      logic nodec;
      logic run;
      logic bank_a;
   } dw_ctl_t;

   localparam int unsigned BYTE_W = 8;
   localparam int unsigned NIB_W  = 4;
endpackage

// File: rtl/dw_sync.sv
module dw_sync #(
   parameter int unsigned W      = 10,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   logic [STAGES-1:0][W-1:0] q;

   if (STAGES < 2) begin : g_bad_stages
      $error("dw_sync needs at least two stages");
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) q[0] <= '0;
            else        q[0] <= din;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) q[s] <= '0;
            else        q[s] <= q[s-1];
      end
   end

   assign dout = q[STAGES-1];
endmodule

// File: rtl/dw_ctrl.sv
module dw_ctrl
   import dw_pkg::*;
#(
   parameter int unsigned DIGITS = 8,
   parameter int unsigned AW     = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ctl_wr,
   input  logic                dat_wr,
   input  logic [BYTE_W-1:0]   din,
   output dw_ctl_t             ctl,
   output logic                blank,
   output logic                sgl_on,
   output logic [DIGITS-1:0]   we
);
   logic          seq_on;
   logic [AW-1:0] seq_idx;
   logic [AW-1:0] sgl_addr;

   always_comb begin
      we = '0;
      if (dat_wr) begin
         if (seq_on)      we[seq_idx]  = 1'b1;
         else if (sgl_on) we[sgl_addr] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl      <= '{hex: 1'b0, nodec: 1'b0, run: 1'b0, bank_a: 1'b1};
         seq_on   <= 1'b0;
         seq_idx  <= '0;
         sgl_on   <= 1'b0;
         sgl_addr <= '0;
      end else if (ctl_wr) begin
         ctl.hex    <= din[6];
         ctl.nodec  <= din[5];
         ctl.run    <= din[4];
         ctl.bank_a <= din[3];
         seq_idx    <= '0;
         seq_on     <= din[7];
         sgl_on     <= ~din[7];
         sgl_addr   <= din[AW-1:0];
      end else if (dat_wr) begin
         if (seq_on) begin
            if (seq_idx == AW'(DIGITS - 1)) seq_on  <= 1'b0;
            else                            seq_idx <= seq_idx + 1'b1;
         end else begin
            sgl_on <= 1'b0;
         end
      end
   end

   assign blank = seq_on;
endmodule

// File: rtl/dw_store.sv
module dw_store
   import dw_pkg::*;
#(
   parameter int unsigned DIGITS = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [DIGITS-1:0]             we,
   input  logic [BYTE_W-1:0]             din,
   input  logic                          raw_wr,
   input  logic                          bank_a,
   output logic [DIGITS-1:0][NIB_W-1:0]  nib_a,
   output logic [DIGITS-1:0][NIB_W-1:0]  nib_b,
   output logic [DIGITS-1:0]             dp,
   output logic [DIGITS-1:0]             raw
);
   for (genvar i = 0; i < DIGITS; i++) begin : g_digit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            nib_a[i] <= '0;
            nib_b[i] <= '0;
            dp[i]    <= 1'b0;
            raw[i]   <= 1'b0;
         end else if (we[i]) begin
            dp[i]  <= din[7];
            raw[i] <= raw_wr;
            if (raw_wr) begin
               nib_a[i] <= din[3:0];
               nib_b[i] <= din[7:4];
            end else if (bank_a) begin
               nib_a[i] <= din[3:0];
            end else begin
               nib_b[i] <= din[3:0];
            end
         end
      end
   end
endmodule

// File: rtl/disp_wr_ctrl.sv
module disp_wr_ctrl
   import dw_pkg::*;
#(
   parameter int unsigned DIGITS      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned AW         = $clog2(DIGITS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_in,
   input  logic              mode_in,
   input  logic [7:0]        bus_in,
   input  logic [AW-1:0]     rd_sel,
   output logic [7:0]        rd_byte,
   output logic              rd_decoded,
   output logic              blank,
   output logic              shutdown,
   output logic              hex_sel
);
   localparam int unsigned SW = BYTE_W + 2;

   if (DIGITS < 2 || DIGITS > 8 || (1 << AW) != DIGITS) begin : g_bad_digits
      $error("DIGITS must be a power of two between 2 and 8");
   end

   logic [SW-1:0]                s_vec;
   logic                         s_wr, s_mode, wr_q, wr_rise;
   logic [BYTE_W-1:0]            s_data;
   logic                         ctl_wr, dat_wr, sgl_on;
   dw_ctl_t                      ctl;
   logic [DIGITS-1:0]            we;
   logic [DIGITS-1:0][NIB_W-1:0] nib_a, nib_b;
   logic [DIGITS-1:0]            dp, raw;

   dw_sync #(.W(SW), .STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n),
      .din({wr_in, mode_in, bus_in}), .dout(s_vec));

   assign {s_wr, s_mode, s_data} = s_vec;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) wr_q <= 1'b0;
      else        wr_q <= s_wr;

   assign wr_rise = s_wr & ~wr_q;
   assign ctl_wr  = wr_rise &  s_mode;
   assign dat_wr  = wr_rise & ~s_mode;

   dw_ctrl #(.DIGITS(DIGITS), .AW(AW)) i_ctrl (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .dat_wr(dat_wr),
      .din(s_data), .ctl(ctl), .blank(blank), .sgl_on(sgl_on), .we(we));

   dw_store #(.DIGITS(DIGITS)) i_store (
      .clk(clk), .rst_n(rst_n), .we(we), .din(s_data),
      .raw_wr(ctl.nodec), .bank_a(ctl.bank_a),
      .nib_a(nib_a), .nib_b(nib_b), .dp(dp), .raw(raw));

   always_comb begin
      if (raw[rd_sel])
         rd_byte = {nib_b[rd_sel], nib_a[rd_sel]};
      else
         rd_byte = {dp[rd_sel], 3'b000,
                    ctl.bank_a ? nib_a[rd_sel] : nib_b[rd_sel]};
   end

   assign rd_decoded = ~raw[rd_sel];
   assign shutdown   = ~ctl.run;
   assign hex_sel    = ctl.hex;
endmodule

// File: rtl/dw_chk.sv
module dw_chk #(
   parameter int unsigned DIGITS = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                wr_rise,
   input logic                s_mode,
   input logic [7:0]          s_data,
   input logic                blank,
   input logic                shutdown,
   input logic                hex_sel,
   input logic [DIGITS-1:0]   we,
   input logic [DIGITS*10-1:0] st_flat
);
   logic ctl_w, dat_w;
   assign ctl_w = wr_rise &  s_mode;
   assign dat_w = wr_rise & ~s_mode;

   AST_CTL_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_w |=> (shutdown == !$past(s_data[4]) && hex_sel == $past(s_data[6]))); // R2
   AST_FILL_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_w && s_data[7]) |=> blank); // R3
   AST_UNBLANK_ON_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(blank) |-> $past(dat_w)); // R3
   AST_ONE_DIGIT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(we)); // R5
   AST_CTL_KEEPS_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      !dat_w |=> $stable(st_flat)); // R6
endmodule

bind disp_wr_ctrl dw_chk #(.DIGITS(DIGITS)) i_chk (
   .clk(clk), .rst_n(rst_n), .wr_rise(wr_rise), .s_mode(s_mode),
   .s_data(s_data), .blank(blank), .shutdown(shutdown), .hex_sel(hex_sel),
   .we(we), .st_flat({nib_a, nib_b, dp, raw}));

// File: tb/test_disp_wr_ctrl.sv
module test_disp_wr_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_in = 1'b0;
   logic       mode_in = 1'b0;
   logic [7:0] bus_in = 8'h00;
   logic [2:0] rd_sel = 3'd0;
   logic [7:0] rd_byte;
   logic       rd_decoded, blank, shutdown, hex_sel;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // bench-side model
   logic [3:0] ea [8];
   logic [3:0] eb [8];
   logic       edp [8];
   logic       eraw [8];
   logic       m_bank_a = 1'b1, m_nodec = 1'b0, m_hex = 1'b0, m_run = 1'b0;
   logic       m_seq = 1'b0, m_sgl = 1'b0;
   int         m_idx = 0, m_addr = 0;

   always #10 clk = ~clk;

   disp_wr_ctrl i_disp_wr_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_in(wr_in), .mode_in(mode_in),
      .bus_in(bus_in), .rd_sel(rd_sel), .rd_byte(rd_byte),
      .rd_decoded(rd_decoded), .blank(blank), .shutdown(shutdown),
      .hex_sel(hex_sel));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic model_apply(input logic mode, input logic [7:0] d);
      int t;
      if (mode) begin
         m_hex = d[6]; m_nodec = d[5]; m_run = d[4]; m_bank_a = d[3];
         m_seq = d[7]; m_sgl = !d[7]; m_idx = 0; m_addr = int'(d[2:0]);
      end else if (m_seq || m_sgl) begin
         t = m_seq ? m_idx : m_addr;
         edp[t] = d[7];
         eraw[t] = m_nodec;
         if (m_nodec) begin ea[t] = d[3:0]; eb[t] = d[7:4]; end
         else if (m_bank_a) ea[t] = d[3:0];
         else eb[t] = d[3:0];
         if (m_seq) begin
            if (m_idx == 7) m_seq = 1'b0; else m_idx++;
         end else m_sgl = 1'b0;
      end
   endtask

   // R11: strobe high for four cycles, then low for four, data held throughout
   task automatic bus_write(input logic mode, input logic [7:0] d);
      @(negedge clk);
      mode_in = mode; bus_in = d; wr_in = 1'b1;
      repeat (4) @(negedge clk);
      wr_in = 1'b0;
      repeat (4) @(negedge clk);
      model_apply(mode, d);
   endtask

   task automatic check_all(input string tag);
      logic [7:0] e;
      for (int i = 0; i < 8; i++) begin
         rd_sel = 3'(i);
         #1;
         if (eraw[i]) e = {eb[i], ea[i]};
         else e = {edp[i], 3'b000, m_bank_a ? ea[i] : eb[i]};
         chk(tag, {24'd0, rd_byte}, {24'd0, e});
         chk(tag, {31'd0, rd_decoded}, {31'd0, !eraw[i]});
      end
      chk(tag, {31'd0, blank}, {31'd0, m_seq});
      chk(tag, {31'd0, shutdown}, {31'd0, !m_run});
      chk(tag, {31'd0, hex_sel}, {31'd0, m_hex});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog R11 act=hung exp=finished");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 8; i++) begin
         ea[i] = 4'h0; eb[i] = 4'h0; edp[i] = 1'b0; eraw[i] = 1'b0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check_all("R1");
      bus_write(1'b0, 8'h9A);           // R1: data before any control word is dropped
      check_all("R1");

      // R3 + R10: fill into bank A, hex, while in shutdown
      bus_write(1'b1, 8'hC8);
      check_all("R3");
      chk("R10", {31'd0, shutdown}, 32'd1);
      for (int i = 0; i < 8; i++) begin
         bus_write(1'b0, {logic'(i[0]), 3'b000, 4'((i * 5 + 3) & 15)});
         chk("R3", {31'd0, blank}, {31'd0, (i < 7)});
      end
      check_all("R3");

      // R4: write after a completed fill is ignored
      bus_write(1'b0, 8'hFF);
      check_all("R4");

      // R6 + R7: control only, bank B, run, hex
      bus_write(1'b1, 8'h50);
      check_all("R6");

      // R7: fill bank B, dp shared with bank A
      bus_write(1'b1, 8'hD0);
      for (int i = 0; i < 8; i++)
         bus_write(1'b0, {logic'(!i[0]), 3'b000, 4'(15 - i)});
      check_all("R7");
      bus_write(1'b1, 8'h58);            // back to bank A view
      check_all("R7");

      // R5: armed write at every address, bank A
      for (int a = 0; a < 8; a++) begin
         bus_write(1'b1, 8'h58 | 8'(a));
         bus_write(1'b0, 8'h80 | 8'((a * 7) & 15));
         check_all("R5");
         bus_write(1'b0, 8'h0E);         // second data write must be dropped
         check_all("R5");
      end

      // R8: raw writes on digits 5 and 2
      bus_write(1'b1, 8'h75);
      bus_write(1'b0, 8'h3C);
      check_all("R8");
      bus_write(1'b1, 8'h72);
      bus_write(1'b0, 8'hA5);
      check_all("R8");
      bus_write(1'b1, 8'h10);            // bank B view, raw digits unchanged
      check_all("R8");

      // R9: alternate set, decode, bank A; raw flags persist
      bus_write(1'b1, 8'h18);
      check_all("R9");
      chk("R9", {31'd0, hex_sel}, 32'd0);

      // R10: armed decoded write while shut down overwrites raw digit 5 slot A
      bus_write(1'b1, 8'h0D);
      bus_write(1'b0, 8'h87);
      check_all("R10");

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule